// File: doc/BRIEF.md
# Buffered Serial Shift Engine (Master Mode)

This block is the shifting core of a master-mode serial peripheral port. A host write places a word in a one-entry transmit holding register. When the shift register is free, the engine copies that word into it in one step. While the enable input is high and the receive holding register has room, the engine runs a transfer. It generates the serial clock from a divider, drives one bit per serial clock cycle on `mosi`, and samples `miso`. When the last bit has been shifted, it places the captured word in a one-entry receive holding register.

The host configures the transfer length (8, 16 or 32 bits) and the bit order (MSB first or LSB first) with the command inputs. Transfer data always lies in the low-order bits of a word. A transfer cannot begin while the receive holding register is full, so the host must read it first. If a transfer begins with no new transmit write, the shift register is sent as it stands, which means the word received last is echoed back out.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, `tx_empty` is 1, `rx_full` is 0, `busy` is 0, `sclk` is 0 and `rx_data` is 0.
- R2: A `tx_wr` pulse sets `tx_empty` to 0 on the next cycle. If the shift register is empty, the word is copied into it one cycle later and `tx_empty` returns to 1.
- R3: With `cfg_lsb_first`=0, `mosi` sends bit n-1 of the shift register first and bit 0 last, where n is the length. Received bits enter at bit 0 and move toward bit n-1, so the first bit received ends up in bit n-1.
- R4: With `cfg_lsb_first`=1, `mosi` sends bit 0 first. Received bits enter at bit n-1 and move down, so the first bit received ends up in bit 0.
- R5: `cfg_len` selects the length n: 00 gives 8, 01 gives 16, 10 or 11 gives 32. Bits n and above of `rx_data` read 0.
- R6: `sclk` idles low. Each bit takes 2*HALF_DIV clock cycles: the output bit changes on the falling edge and the input is sampled on the rising edge. A transfer keeps `busy` high for exactly 2*HALF_DIV*n cycles.
- R7: When a transfer completes, the received word is copied to `rx_data` and `rx_full` goes to 1. Asserting `rx_rd` drops `rx_full` in the same cycle.
- R8: While the receive holding register is full, no transfer starts, even if `en` is high.
- R9: A transfer that starts with no new transmit word shifts out the word that was received last.
- R10: Dropping `en` during a transfer aborts it on the next clock. `busy` and `sclk` go low, the shift register is marked empty, and no word is delivered.
- R11: `busy` is 1 from the first cycle of a transfer until its last bit completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Transfer enable; low aborts any transfer in progress |
| cfg_len | input | 2 | Length select: 00=8, 01=16, 1x=32 |
| cfg_lsb_first | input | 1 | 1 = LSB-first order, 0 = MSB-first order |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 32 | Transmit word |
| rx_rd | input | 1 | Read strobe for the receive holding register |
| rx_data | output | 32 | Receive word, zero above the length |
| tx_empty | output | 1 | Transmit holding register is empty |
| rx_full | output | 1 | Receive holding register holds an unread word |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong bit order or wrong length decode shows up as a reversed or truncated `rx_data`, and in the `mosi` sequence captured by the slave model, at the end of the very transfer it affects. A shift register that is not marked empty when it should be would leave `tx_empty` stuck at 0 within two cycles of a write. A missed stall or a missed abort would show `busy` rising while `rx_full` is high, or staying high one cycle after `en` drops. The duration of `busy` is counted for every transfer, so a divider or bit-count error appears as a wrong cycle count.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int MAX_W = 32;
  typedef logic [MAX_W-1:0] word_t;

  // length select encoding
  typedef enum logic [1:0] {
    LEN_8   = 2'b00,
    LEN_16  = 2'b01,
    LEN_32  = 2'b10,
    LEN_32X = 2'b11
  } len_sel_e;

  function automatic int unsigned len_bits(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8;
      2'b01:   return 16;
      default: return 32;
    endcase
  endfunction

  function automatic word_t len_mask(input logic [1:0] sel);
    logic [63:0] wide;
    wide = (64'd1 << len_bits(sel)) - 64'd1;
    return wide[MAX_W-1:0];
  endfunction

  // one shift step with incoming bit b; result limited to the active length
  function automatic word_t shift_in(input word_t w, input logic b,
                                     input logic [1:0] sel, input logic lsb);
    word_t r;
    if (!lsb) begin
      r = {w[MAX_W-2:0], b};
    end else begin
      r = w >> 1;
      r[len_bits(sel)-1] = b;
    end
    return r & len_mask(sel);
  endfunction

  function automatic logic first_out(input word_t w, input logic [1:0] sel,
                                     input logic lsb);
    return lsb ? w[0] : w[len_bits(sel)-1];
  endfunction
endpackage

// File: rtl/spi_hold_reg.sv
module spi_hold_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         clr,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (wr) begin
      valid <= 1'b1;
      data  <= wdata;
    end else if (clr) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = $clog2(HALF_DIV + 1);
  logic [CW-1:0] cnt;
  logic          lvl;
  logic          tick;

  assign tick     = run && (cnt == CW'(HALF_DIV - 1));
  assign rise_evt = tick && !lvl;
  assign fall_evt = tick && lvl;
  assign sclk     = lvl && run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      lvl <= ~lvl;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: a rising edge event is never followed at once by another one
  a_r6_edges_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !rise_evt);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  word_t      load_word,
  input  logic       rise_evt,
  input  logic       fall_evt,
  input  logic       miso,
  input  logic [1:0] len_sel,
  input  logic       lsb_first,
  output word_t      next_word,
  output logic       out_bit
);
  word_t sr;
  logic  samp;

  assign next_word = shift_in(sr, samp, len_sel, lsb_first);
  assign out_bit   = first_out(sr, len_sel, lsb_first);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      samp <= 1'b0;
    end else begin
      if (rise_evt) samp <= miso;
      if (load)          sr <= load_word;
      else if (fall_evt) sr <= next_word;
    end
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [1:0]  cfg_len,
  input  logic        cfg_lsb_first,
  input  logic        tx_wr,
  input  logic [31:0] tx_data,
  input  logic        rx_rd,
  output logic [31:0] rx_data,
  output logic        tx_empty,
  output logic        rx_full,
  output logic        busy,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam int BCW = $clog2(MAX_W);

  logic           busy_q, sr_full;
  logic [1:0]     len_q;
  logic           lsb_q;
  logic [BCW-1:0] bitcnt;
  logic           tx_valid, rx_full_q;
  word_t          tx_word, rx_word, next_word;
  logic           rise_evt, fall_evt;

  // named internal events
  logic load_evt, start_evt, last_bit, done_evt, abort_evt;
  assign load_evt  = tx_valid && !sr_full;
  assign start_evt = en && !busy_q && !rx_full_q && !load_evt;
  assign last_bit  = (bitcnt == BCW'(len_bits(len_q) - 1));
  assign done_evt  = busy_q && en && fall_evt && last_bit;
  assign abort_evt = busy_q && !en;

  spi_hold_reg #(.W(MAX_W)) u_txbuf (
    .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_data),
    .clr(load_evt), .valid(tx_valid), .data(tx_word));

  spi_hold_reg #(.W(MAX_W)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .wr(done_evt), .wdata(next_word),
    .clr(rx_rd), .valid(rx_full_q), .data(rx_word));

  spi_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .sclk(sclk),
    .rise_evt(rise_evt), .fall_evt(fall_evt));

  spi_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .load_word(tx_word),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .miso(miso),
    .len_sel(len_q), .lsb_first(lsb_q), .next_word(next_word),
    .out_bit(mosi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sr_full <= 1'b0;
      len_q   <= LEN_32;
      lsb_q   <= 1'b0;
      bitcnt  <= '0;
    end else begin
      if (abort_evt || done_evt) begin
        busy_q  <= 1'b0;
        sr_full <= 1'b0;
      end else if (start_evt) begin
        busy_q  <= 1'b1;
        sr_full <= 1'b1;
        len_q   <= cfg_len;
        lsb_q   <= cfg_lsb_first;
        bitcnt  <= '0;
      end else if (load_evt) begin
        sr_full <= 1'b1;
      end
      if (busy_q && fall_evt && !last_bit) bitcnt <= bitcnt + 1'b1;
    end
  end

  assign busy     = busy_q;
  assign tx_empty = !tx_valid;
  assign rx_full  = rx_full_q && !rx_rd;
  assign rx_data  = rx_word;

  // R2: a copy into the shift register frees the transmit register
  a_r2_load_frees_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !tx_wr) |=> (!tx_valid && sr_full));
  // R7: a completed transfer leaves a word waiting
  a_r7_done_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> rx_full_q);
  // R8: no start while the receive register is occupied
  a_r8_stall_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full_q && !busy_q) |=> !busy_q);
  // R10: enable low ends any transfer by the next clock
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy_q && !sclk));
  // R5: bits above the length stay clear in the delivered word
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_q |-> ((rx_word & ~len_mask(len_q)) == '0));
  // R11: a start raises busy with the serial clock still low
  a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy_q && !sclk));
endmodule

// File: tb/spi_xfer_engine_tb.sv
module spi_xfer_engine_tb_top;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  cfg_len = 2'b10;
  logic        cfg_lsb_first = 1'b0;
  logic        tx_wr = 1'b0;
  logic [31:0] tx_data = '0;
  logic        rx_rd = 1'b0;
  logic [31:0] rx_data;
  logic        tx_empty, rx_full, busy, sclk, mosi, miso;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_xfer_engine #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_len(cfg_len),
    .cfg_lsb_first(cfg_lsb_first), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_rd(rx_rd), .rx_data(rx_data), .tx_empty(tx_empty),
    .rx_full(rx_full), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso));

  function automatic int nbits(input logic [1:0] s);
    return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
  endfunction

  function automatic logic [31:0] mask_of(input logic [1:0] s);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < nbits(s); i++) m[i] = 1'b1;
    return m;
  endfunction

  // word as seen on the line: first bit sent placed at position n-1
  function automatic logic [31:0] line_order(input logic [31:0] w,
                                             input logic [1:0] s, input logic lsb);
    logic [31:0] r;
    int n;
    n = nbits(s);
    r = '0;
    for (int k = 0; k < n; k++) r[n-1-k] = lsb ? w[k] : w[n-1-k];
    return r;
  endfunction

  // slave model
  logic [31:0] slave_word = '0;
  logic [31:0] cap = '0;
  int idx = 0;
  always @(posedge busy) begin idx = 0; cap = '0; end
  always @(negedge sclk) idx = idx + 1;
  always @(posedge sclk) cap = {cap[30:0], mosi};

  function automatic logic slave_bit(input logic [31:0] w, input int k,
                                     input logic [1:0] s, input logic lsb);
    int n;
    n = nbits(s);
    if (k >= n) return 1'b0;
    return lsb ? w[k] : w[n-1-k];
  endfunction
  assign miso = slave_bit(slave_word, idx, cfg_len, cfg_lsb_first);

  task automatic check(input string req, input logic ok,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] last_rx = '0;

  task automatic xfer(input logic [1:0] ls, input logic lsb, input logic use_tx,
                      input logic [31:0] txw, input logic [31:0] slv,
                      input logic [31:0] exp_out);
    int bcyc;
    int stall_bad;
    logic [31:0] m;
    m = mask_of(ls);
    cfg_len = ls; cfg_lsb_first = lsb; slave_word = slv;
    if (use_tx) begin
      tx_wr = 1'b1; tx_data = txw;
      @(negedge clk); tx_wr = 1'b0;
      check("R2 tx_empty low after write", tx_empty == 1'b0, 32'(tx_empty), 32'd0);
      @(negedge clk);
      check("R2 tx_empty high after copy", tx_empty == 1'b1, 32'(tx_empty), 32'd1);
    end
    en = 1'b1;
    bcyc = 0;
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk);
      if (busy) bcyc++;
      if (rx_full) break;
    end
    stall_bad = 0;
    repeat (8) begin
      @(negedge clk);
      if (busy) stall_bad++;
    end
    check("R8 no start while rx full", stall_bad == 0, 32'(stall_bad), 32'd0);
    en = 1'b0;
    check("R6 busy length", bcyc == 2*HALF*nbits(ls), 32'(bcyc), 32'(2*HALF*nbits(ls)));
    check(lsb ? "R4 rx word lsb-first" : "R3 rx word msb-first",
          rx_data == (slv & m), rx_data, slv & m);
    check("R5 upper rx bits zero", (rx_data & ~m) == '0, rx_data & ~m, 32'd0);
    check(use_tx ? "R3/R4 mosi order" : "R9 echo of last rx",
          cap == line_order(exp_out & m, ls, lsb), cap, line_order(exp_out & m, ls, lsb));
    last_rx = rx_data;
    rx_rd = 1'b1;
    #1;
    check("R7 rx_full drops with read", rx_full == 1'b0, 32'(rx_full), 32'd0);
    @(negedge clk); rx_rd = 1'b0;
    check("R7 rx_full stays low", rx_full == 1'b0, 32'(rx_full), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 tx_empty", tx_empty == 1'b1, 32'(tx_empty), 32'd1);
    check("R1 rx_full", rx_full == 1'b0, 32'(rx_full), 32'd0);
    check("R1 busy", busy == 1'b0, 32'(busy), 32'd0);
    check("R1 sclk", sclk == 1'b0, 32'(sclk), 32'd0);
    check("R1 rx_data", rx_data == '0, rx_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    xfer(2'b10, 1'b0, 1'b1, 32'hA5C3_0F81, 32'h1234_5678, 32'hA5C3_0F81);
    xfer(2'b00, 1'b1, 1'b1, 32'hFFFF_FF01, 32'hDEAD_BE2D, 32'hFFFF_FF01);
    xfer(2'b01, 1'b0, 1'b1, 32'h0000_8001, 32'hCAFE_F00D, 32'h0000_8001);
    xfer(2'b11, 1'b1, 1'b1, 32'h8000_0001, 32'h0BAD_CAFE, 32'h8000_0001);
    // R9 echo: no new write, last received word goes back out
    xfer(2'b01, 1'b1, 1'b0, 32'h0, 32'h5A5A_3C3C, last_rx);

    // R10 abort mid transfer
    cfg_len = 2'b10; cfg_lsb_first = 1'b0;
    tx_wr = 1'b1; tx_data = 32'h1357_9BDF;
    @(negedge clk); tx_wr = 1'b0;
    @(negedge clk);
    en = 1'b1;
    repeat (12) @(negedge clk);
    check("R11 busy during transfer", busy == 1'b1, 32'(busy), 32'd1);
    en = 1'b0;
    @(negedge clk);
    check("R10 busy low after abort", busy == 1'b0, 32'(busy), 32'd0);
    check("R10 sclk low after abort", sclk == 1'b0, 32'(sclk), 32'd0);
    check("R10 no word delivered", rx_full == 1'b0, 32'(rx_full), 32'd0);

    for (int i = 0; i < 12; i++) begin
      logic [1:0]  ls;
      logic        lsb, ut;
      logic [31:0] tw, sw;
      ls  = 2'($urandom % 4);
      lsb = 1'($urandom % 2);
      ut  = (i == 0) || (($urandom % 4) != 0);
      tw  = $urandom;
      sw  = $urandom;
      xfer(ls, lsb, ut, tw, sw, ut ? tw : last_rx);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule